// File: doc/BRIEF.md
# Supervisor Reset Generator

This block produces the system reset for a six-channel voltage supervisor. It takes one undervoltage flag and one overvoltage flag per channel, with the flags coming from comparators outside the block. Reset is held for as long as the boot phase lasts. After boot, reset is released only when every watched channel has stayed inside its limits for a programmable timeout. The timeout is counted on a 1 ms tick, which a prescaler derives from the clock.

During normal operation, reset reasserts in these cases:
- an undervoltage flag is raised on a channel selected in the undervoltage mask;
- an overvoltage flag is raised on a channel selected in the overvoltage mask;
- either flag is raised on a channel marked critical, whatever the two masks say.

Software can also request a single reset pulse, and that pulse lasts exactly one timeout. The pad can be driven push-pull or open-drain, with either polarity. The logical reset state is readable as a status bit.

Top module: `reset_supervisor`

## Requirements
- R1: While `boot_done` is low, `rst_status` is 1 from the clock edge after it is sampled low.
- R2: A 4-bit `tmo_code` selects a release timeout L in ms. Codes 0 to 15 give 1, 1, 2, 4, 8, 16, 25, 50, 100, 200, 400, 600, 800, 1000, 1200 and 1600 ms. After reset is asserted with no selected violation, `rst_status` falls between L*TICK_DIV and L*TICK_DIV+3 clock cycles after the last change that cleared the violation.
- R3: Bit i of `uv_sel` makes `uv_flags[i]` assert reset, one clock after it is sampled. Undervoltage flags on unselected, non-critical channels have no effect.
- R4: Bit i of `ov_sel` makes `ov_flags[i]` assert reset, one clock after it is sampled. Overvoltage flags on unselected, non-critical channels have no effect.
- R5: When `crit_mask[i]` is 1, either flag of channel i asserts reset, even if both select masks are 0.
- R6: With `open_drain` = 0, `pad_oe` is 1. `pad_out` equals `rst_status` when `active_high` = 1, and equals its inverse when `active_high` = 0.
- R7: With `open_drain` = 1, `pad_out` is always 0. `pad_oe` is 1 exactly when the required pad level is low, which is asserted with active-low polarity or released with active-high polarity.
- R8: A one-cycle `pulse_req` while reset is released sets `pulse_bit`. One cycle later `rst_status` rises and stays high for one timeout (the R2 window), then falls.
- R9: `pulse_bit` clears on the cycle after it is set. A request made while reset is asserted leaves no pulse behind.
- R10: A selected violation during the release countdown restarts the countdown from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_done | input | 1 | High once the boot phase is over |
| uv_flags | input | 6 | Undervoltage flag per channel |
| ov_flags | input | 6 | Overvoltage flag per channel |
| crit_mask | input | 6 | Channels whose faults always assert reset |
| uv_sel | input | 6 | Channels whose undervoltage asserts reset |
| ov_sel | input | 6 | Channels whose overvoltage asserts reset |
| tmo_code | input | 4 | Release timeout code |
| active_high | input | 1 | 1: asserted pad level is high |
| open_drain | input | 1 | 1: open-drain drive, 0: push-pull |
| pulse_req | input | 1 | Write strobe for the one-shot pulse bit |
| pad_out | output | 1 | Pad drive value |
| pad_oe | output | 1 | Pad output enable |
| rst_status | output | 1 | Logical reset state, 1 = asserted |
| pulse_bit | output | 1 | Self-clearing one-shot request bit |

## Verification
The assertions assume that the flags, masks and configuration inputs change only between clock edges and stay valid for the whole cycle in which they are sampled. They also assume that `pulse_req` is a single-cycle strobe. The bench drives every input at the falling edge and asserts `pulse_req` for exactly one cycle. It changes `tmo_code` only while reset is released or held in boot, so a countdown never sees its limit change midway.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int NCH  = 6;
  localparam int MS_W = 11;

  function automatic logic [MS_W-1:0] timeout_ms(input logic [3:0] code);
    case (code)
      4'd0:    timeout_ms = 11'd1;
      4'd1:    timeout_ms = 11'd1;
      4'd2:    timeout_ms = 11'd2;
      4'd3:    timeout_ms = 11'd4;
      4'd4:    timeout_ms = 11'd8;
      4'd5:    timeout_ms = 11'd16;
      4'd6:    timeout_ms = 11'd25;
      4'd7:    timeout_ms = 11'd50;
      4'd8:    timeout_ms = 11'd100;
      4'd9:    timeout_ms = 11'd200;
      4'd10:   timeout_ms = 11'd400;
      4'd11:   timeout_ms = 11'd600;
      4'd12:   timeout_ms = 11'd800;
      4'd13:   timeout_ms = 11'd1000;
      4'd14:   timeout_ms = 11'd1200;
      default: timeout_ms = 11'd1600;
    endcase
  endfunction

  function automatic logic [1:0] pad_drive(input logic asserted, input logic act_hi,
                                           input logic od);
    logic level;
    level = act_hi ? asserted : ~asserted;
    pad_drive = od ? {1'b0, ~level} : {level, 1'b1};
  endfunction

  typedef enum logic [1:0] {
    ST_BOOT  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_RUN   = 2'd2,
    ST_PULSE = 2'd3
  } rs_state_e;
endpackage

// File: rtl/rs_fault_select.sv
module rs_fault_select #(
  parameter int NCH = 6
) (
  input  logic [NCH-1:0] uv_flags,
  input  logic [NCH-1:0] ov_flags,
  input  logic [NCH-1:0] crit_mask,
  input  logic [NCH-1:0] uv_sel,
  input  logic [NCH-1:0] ov_sel,
  output logic           fault
);
  logic [NCH-1:0] ch_hit;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_hit[i] = (uv_flags[i] & (uv_sel[i] | crit_mask[i])) |
                       (ov_flags[i] & (ov_sel[i] | crit_mask[i]));
  end

  assign fault = |ch_hit;
endmodule

// File: rtl/rs_release_timer.sv
module rs_release_timer #(
  parameter int TICK_DIV = 125000,
  parameter int MS_W     = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [MS_W-1:0] limit,
  output logic            done
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic            tick;
  logic [MS_W-1:0] ms_cnt;

  if (TICK_DIV > 1) begin : g_pre
    logic [PRE_W-1:0] pre_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  pre_cnt <= '0;
      else if (clr)                                pre_cnt <= '0;
      else if (pre_cnt == PRE_W'(TICK_DIV - 1))    pre_cnt <= '0;
      else                                         pre_cnt <= pre_cnt + 1'b1;
    end
    assign tick = !clr && (pre_cnt == PRE_W'(TICK_DIV - 1));
  end else begin : g_nopre
    assign tick = !clr;
  end

  assign done = (ms_cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ms_cnt <= '0;
    else if (clr)            ms_cnt <= '0;
    else if (tick && !done)  ms_cnt <= ms_cnt + 1'b1;
  end
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
  import rs_pkg::*;
#(
  parameter int TICK_DIV = 125000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           boot_done,
  input  logic [NCH-1:0] uv_flags,
  input  logic [NCH-1:0] ov_flags,
  input  logic [NCH-1:0] crit_mask,
  input  logic [NCH-1:0] uv_sel,
  input  logic [NCH-1:0] ov_sel,
  input  logic [3:0]     tmo_code,
  input  logic           active_high,
  input  logic           open_drain,
  input  logic           pulse_req,
  output logic           pad_out,
  output logic           pad_oe,
  output logic           rst_status,
  output logic           pulse_bit
);
  rs_state_e       state;
  logic            fault_w;
  logic            tmr_clr;
  logic            tmr_done_w;
  logic [MS_W-1:0] limit_w;
  logic [1:0]      drive_w;

  rs_fault_select #(.NCH(NCH)) u_sel (
    .uv_flags  (uv_flags),
    .ov_flags  (ov_flags),
    .crit_mask (crit_mask),
    .uv_sel    (uv_sel),
    .ov_sel    (ov_sel),
    .fault     (fault_w)
  );

  assign limit_w = timeout_ms(tmo_code);
  assign tmr_clr = fault_w || !boot_done || (state == ST_BOOT) || (state == ST_RUN);

  rs_release_timer #(.TICK_DIV(TICK_DIV), .MS_W(MS_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .limit (limit_w),
    .done  (tmr_done_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_BOOT;
    end else if (!boot_done) begin
      state <= ST_BOOT;
    end else if (fault_w) begin
      state <= ST_HOLD;
    end else begin
      case (state)
        ST_BOOT:  state <= ST_HOLD;
        ST_HOLD:  if (tmr_done_w) state <= ST_RUN;
        ST_RUN:   if (pulse_bit) state <= ST_PULSE;
        default:  if (tmr_done_w) state <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pulse_bit <= 1'b0;
    else if (pulse_req) pulse_bit <= 1'b1;
    else                pulse_bit <= 1'b0;
  end

  assign rst_status = (state != ST_RUN);
  assign drive_w    = pad_drive(rst_status, active_high, open_drain);
  assign pad_out    = drive_w[1];
  assign pad_oe     = drive_w[0];
endmodule

// File: rtl/rs_checker.sv
module rs_checker (
  input logic clk,
  input logic rst_n,
  input logic boot_done,
  input logic pulse_req,
  input logic fault_w,
  input logic tmr_done_w,
  input logic pulse_bit,
  input logic rst_status,
  input logic pad_out,
  input logic pad_oe,
  input logic open_drain
);
  // R1
  boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |=> rst_status);

  // R5
  fault_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && fault_w) |=> rst_status);

  // R2
  release_after_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_status) |-> $past(tmr_done_w));

  // R10
  countdown_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && fault_w) |=> !tmr_done_w);

  // R7
  open_drain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_drain |-> !pad_out);

  // R6
  push_pull_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open_drain |-> pad_oe);

  // R9
  pulse_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_bit && !pulse_req) |=> !pulse_bit);
endmodule

bind reset_supervisor rs_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .boot_done  (boot_done),
  .pulse_req  (pulse_req),
  .fault_w    (fault_w),
  .tmr_done_w (tmr_done_w),
  .pulse_bit  (pulse_bit),
  .rst_status (rst_status),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .open_drain (open_drain)
);

// File: tb/sim_reset_supervisor.sv
`timescale 1ns/1ps
module sim_reset_supervisor;
  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boot_done = 1'b0;
  logic [5:0] uv_flags = '0, ov_flags = '0, crit_mask = '0, uv_sel = '0, ov_sel = '0;
  logic [3:0] tmo_code = '0;
  logic       active_high = 1'b0, open_drain = 1'b0, pulse_req = 1'b0;
  logic       pad_out, pad_oe, rst_status, pulse_bit;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  reset_supervisor #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .boot_done(boot_done),
    .uv_flags(uv_flags), .ov_flags(ov_flags), .crit_mask(crit_mask),
    .uv_sel(uv_sel), .ov_sel(ov_sel), .tmo_code(tmo_code),
    .active_high(active_high), .open_drain(open_drain), .pulse_req(pulse_req),
    .pad_out(pad_out), .pad_oe(pad_oe), .rst_status(rst_status), .pulse_bit(pulse_bit)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic int ms_of(input logic [3:0] c);
    int tbl [16] = '{1, 1, 2, 4, 8, 16, 25, 50, 100, 200, 400, 600, 800, 1000, 1200, 1600};
    return tbl[c];
  endfunction

  function automatic logic exp_fault(input logic [5:0] uv, ov, cr, us, os);
    return |((uv & us) | (ov & os) | ((uv | ov) & cr));
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_pad(input string req);
    logic lvl;
    logic exp_o, exp_e;
    lvl = active_high ? rst_status : !rst_status;
    if (open_drain) begin exp_o = 1'b0; exp_e = (lvl == 1'b0); end
    else begin exp_o = lvl; exp_e = 1'b1; end
    check(pad_out == exp_o && pad_oe == exp_e, req, {pad_out, pad_oe}, {exp_o, exp_e});
  endtask

  task automatic measure_release(output int n);
    n = 0;
    while (rst_status && n < 8000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_window(input int n, input logic [3:0] code, input string req);
    int t;
    t = ms_of(code) * DIV;
    check(n >= t && n <= t + 3, req, n, t);
  endtask

  task automatic clear_flags();
    uv_flags = '0; ov_flags = '0;
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rst_status == 1'b1, "R1", rst_status, 1);
    check_pad("R6");
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(rst_status == 1'b1, "R1", rst_status, 1);

    // R2 release timing for several codes
    foreach (tmo_code_list[k]) begin end
    for (int k = 0; k < 4; k++) begin
      logic [3:0] c;
      c = (k == 0) ? 4'd0 : (k == 1) ? 4'd4 : (k == 2) ? 4'd9 : 4'd15;
      boot_done = 1'b0;
      @(negedge clk);
      tmo_code = c;
      boot_done = 1'b1;
      measure_release(n);
      check_window(n, c, "R2");
    end

    // R1 boot drop reasserts
    boot_done = 1'b0;
    @(negedge clk);
    check(rst_status == 1'b1, "R1", rst_status, 1);
    tmo_code = 4'd2;
    boot_done = 1'b1;
    measure_release(n);
    check_window(n, 4'd2, "R2");

    // R3 undervoltage selection
    uv_sel = 6'b000100;
    uv_flags = 6'b001000;
    repeat (5) @(negedge clk);
    check(rst_status == 1'b0, "R3", rst_status, 0);
    uv_flags = 6'b000100;
    @(negedge clk);
    check(rst_status == 1'b1, "R3", rst_status, 1);
    clear_flags();
    measure_release(n);
    check_window(n, 4'd2, "R3");

    // R4 overvoltage selection
    uv_sel = 6'b111111; ov_sel = 6'b100000;
    ov_flags = 6'b011111;
    repeat (5) @(negedge clk);
    check(rst_status == 1'b0, "R4", rst_status, 0);
    ov_flags = 6'b100000;
    @(negedge clk);
    check(rst_status == 1'b1, "R4", rst_status, 1);
    clear_flags();
    measure_release(n);

    // R5 critical override
    uv_sel = '0; ov_sel = '0; crit_mask = 6'b000010;
    ov_flags = 6'b000010;
    @(negedge clk);
    check(rst_status == 1'b1, "R5", rst_status, 1);
    clear_flags();
    measure_release(n);
    uv_flags = 6'b000010;
    @(negedge clk);
    check(rst_status == 1'b1, "R5", rst_status, 1);
    clear_flags();
    measure_release(n);
    crit_mask = '0;

    // R10 countdown restart
    tmo_code = 4'd6;
    uv_sel = 6'b000001; uv_flags = 6'b000001;
    @(negedge clk);
    clear_flags();
    repeat (30) @(negedge clk);
    check(rst_status == 1'b1, "R10", rst_status, 1);
    uv_flags = 6'b000001;
    @(negedge clk);
    clear_flags();
    measure_release(n);
    check_window(n, 4'd6, "R10");

    // R8 one-shot pulse
    tmo_code = 4'd5;
    pulse_req = 1'b1;
    @(negedge clk);
    pulse_req = 1'b0;
    check(pulse_bit == 1'b1 && rst_status == 1'b0, "R8", {pulse_bit, rst_status}, 2);
    @(negedge clk);
    check(pulse_bit == 1'b0, "R9", pulse_bit, 0);
    check(rst_status == 1'b1, "R8", rst_status, 1);
    measure_release(n);
    check_window(n + 1, 4'd5, "R8");

    // R9 request while asserted is dropped
    uv_flags = 6'b000001;
    @(negedge clk);
    pulse_req = 1'b1;
    @(negedge clk);
    pulse_req = 1'b0;
    check(pulse_bit == 1'b1, "R9", pulse_bit, 1);
    @(negedge clk);
    check(pulse_bit == 1'b0, "R9", pulse_bit, 0);
    clear_flags();
    measure_release(n);
    repeat (100) @(negedge clk);
    check(rst_status == 1'b0, "R9", rst_status, 0);

    // R6 / R7 pad modes, released then asserted
    for (int m = 0; m < 4; m++) begin
      active_high = m[0]; open_drain = m[1];
      @(negedge clk);
      check_pad(open_drain ? "R7" : "R6");
      uv_flags = 6'b000001;
      @(negedge clk);
      check_pad(open_drain ? "R7" : "R6");
      clear_flags();
      measure_release(n);
    end

    // random masks and flags
    void'($urandom(32'd2024));
    for (int it = 0; it < 60; it++) begin
      logic e;
      tmo_code = 4'($urandom_range(0, 5));
      active_high = 1'($urandom); open_drain = 1'($urandom);
      uv_sel = 6'($urandom); ov_sel = 6'($urandom);
      crit_mask = 6'($urandom & $urandom);
      uv_flags = 6'($urandom & $urandom & $urandom);
      ov_flags = 6'($urandom & $urandom & $urandom);
      e = exp_fault(uv_flags, ov_flags, crit_mask, uv_sel, ov_sel);
      @(negedge clk);
      check(rst_status == e, e ? "R5" : "R3", rst_status, e);
      check_pad(open_drain ? "R7" : "R6");
      clear_flags();
      if (e) begin
        measure_release(n);
        check_window(n, tmo_code, "R2");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  logic [3:0] tmo_code_list [1] = '{4'd0};
endmodule